// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a simple synchronous host port and a DRAM device whose row and column addresses share a single address bus. Each host read or write is accepted through a request/ready handshake. The block splits the address into a row part and a column part and plays them out in turn, framed by row and column strobes. Every memory cycle uses the same four phases, T1 to T4.

A row that has been opened stays open while the block is idle. If the next request targets the same row, the block skips the two row phases and goes straight to the column phases. A built-in interval timer requests periodic refresh cycles. Each refresh strobes the row given by a rolling refresh-row counter and closes any open row.

Read data comes back on a separate host bus with a one-cycle valid pulse. Write data is held on a separate device-side bus while the column strobe is active.

Top module: `dram_seq`

## Requirements
- R1: After reset the block is idle. `host_ready`=1, `dram_cs_n`=1, `dram_ras_n`=1, `dram_cas_n`=1, `dram_rw`=1, `dram_oe_n`=1 and `host_rvalid`=0.
- R2: A request whose row is not open runs through four phases.
  - T1: `dram_cs_n`=0, `dram_ras_n`=1 (any open row is closed), and the bus carries the row, which is `host_addr[ROW_W+COL_W-1:COL_W]`.
  - T2: `dram_ras_n`=0 with the row still on the bus.
  - T3 and T4: `dram_cas_n`=0 and the bus carries the column, which is `host_addr[COL_W-1:0]`.
  - After T4 the block returns to idle with `dram_ras_n` held at 0.
- R3: `dram_rw` is 0 (write level) only in T3 and T4 of a write. Otherwise it is 1 (read level). `dram_wdata` carries the accepted write data during those phases.
- R4: `dram_oe_n` is 0 only in T3 and T4 of a read. `dram_rdata` is captured at the clock edge that ends T4. In the following cycle `host_rvalid`=1 for exactly one cycle, and `host_rdata` holds the captured word.
- R5: Some requests target the row that is currently open. Such a request is accepted and its next phase is T3: no T1 or T2 is issued, and `dram_ras_n` stays 0 throughout.
- R6: An interval timer counts clock cycles. Every `REF_INTERVAL` cycles it raises a refresh request. That request stays pending until a refresh cycle starts.
- R7: A refresh cycle keeps `dram_cas_n`=1 in all four phases. In T1 it drives `dram_ras_n`=1. In T2 and T3 it drives `dram_ras_n`=0, and the bus carries the refresh row. In T4 it drives `dram_ras_n`=1. The refresh row then increments, and it wraps from 2^ROW_W-1 to 0.
- R8: A refresh request that comes up during an access waits until that access finishes T4. An idle cycle with a refresh pending starts the refresh and does not accept the host request. `host_ready` is 0 whenever a refresh is pending.
- R9: A refresh closes the open row. The next access therefore always starts at T1, even when its row equals the row that was open before the refresh.
- R10: `dram_cs_n` is 0 exactly during phases T1 to T4. While idle, `dram_cas_n`=1, `dram_rw`=1, `dram_oe_n`=1, and the bus is 0.
- R11: A request is taken only in a cycle where `host_req` and `host_ready` are both 1. Every accepted read produces exactly one `host_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| host_req | input | 1 | Host request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address, with the row in the upper bits |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Request can be taken this cycle |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| dram_cs_n | output | 1 | Device select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_rw | output | 1 | 1 = read, 0 = write |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_wdata | output | DATA_W | Data to the device |
| dram_rdata | input | DATA_W | Data from the device |

## Verification
A refresh request and a host request can arrive in the same idle cycle. A refresh can also fall due in the middle of an access.

The bench makes both happen often. It uses a refresh interval that does not divide evenly into the access length, and it issues long streams of requests with gaps of zero to two cycles. It counts the collisions it produces.

On every cycle, a behavioural model decides which request wins and what the strobes and address bus must show. The bench compares the design against that model. The bench also checks that the refresh ran before the host access and that the host access was then a full row cycle rather than a page hit.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_REF = 2'd2
  } op_t;

endpackage

// File: rtl/dram_seq_refresh.sv
// Refresh interval timer, pending flag and refresh-row counter.
module dram_seq_refresh #(
  parameter int ROW_W        = 4,
  parameter int REF_INTERVAL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [TW-1:0] TMR_LAST = TW'(REF_INTERVAL - 1);
  localparam int NUM_ROWS = 1 << ROW_W;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  logic [TW-1:0]    tmr_q, tmr_nx;
  logic             pend_nx;
  logic [ROW_W-1:0] row_nx;
  logic             wrap;

  always_comb begin
    wrap   = (tmr_q == TMR_LAST);
    tmr_nx = wrap ? '0 : tmr_q + 1'b1;
    // A new interval expiry wins over the grant that clears the flag.
    if (wrap)
      pend_nx = 1'b1;
    else if (grant_i)
      pend_nx = 1'b0;
    else
      pend_nx = pend_o;
    if (done_i)
      row_nx = (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
    else
      row_nx = row_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      tmr_q  <= tmr_nx;
      pend_o <= pend_nx;
      row_o  <= row_nx;
    end
  end

endmodule

// File: rtl/dram_seq_fsm.sv
// Phase sequencer, request capture and open-row tracking.
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   ref_pend_i,
  output phase_t                 phase_o,
  output op_t                    op_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic                   row_open_o,
  output logic                   ready_o,
  output logic                   accept_o,
  output logic                   grant_o,
  output logic                   ref_done_o,
  output logic                   hit_o
);
  localparam int AW = ROW_W + COL_W;

  phase_t           phase_nx;
  op_t              op_nx;
  logic             open_nx;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign req_row = addr_i[AW-1:COL_W];
  assign req_col = addr_i[COL_W-1:0];

  always_comb begin
    hit_o      = row_open_o && (req_row == row_o);
    ready_o    = (phase_o == ST_IDLE) && !ref_pend_i;
    ref_done_o = (phase_o == ST_T4) && (op_o == OP_REF);
    phase_nx   = phase_o;
    op_nx      = op_o;
    open_nx    = row_open_o;
    accept_o   = 1'b0;
    grant_o    = 1'b0;
    case (phase_o)
      ST_IDLE: begin
        if (ref_pend_i) begin
          grant_o  = 1'b1;
          op_nx    = OP_REF;
          open_nx  = 1'b0;
          phase_nx = ST_T1;
        end else if (req_i) begin
          accept_o = 1'b1;
          op_nx    = we_i ? OP_WR : OP_RD;
          open_nx  = 1'b1;
          phase_nx = hit_o ? ST_T3 : ST_T1;
        end
      end
      ST_T1:   phase_nx = ST_T2;
      ST_T2:   phase_nx = ST_T3;
      ST_T3:   phase_nx = ST_T4;
      ST_T4:   phase_nx = ST_IDLE;
      default: phase_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o    <= ST_IDLE;
      op_o       <= OP_RD;
      row_open_o <= 1'b0;
    end else begin
      phase_o    <= phase_nx;
      op_o       <= op_nx;
      row_open_o <= open_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o   <= '0;
      col_o   <= '0;
      wdata_o <= '0;
    end else if (accept_o) begin
      row_o   <= req_row;
      col_o   <= req_col;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/dram_seq_drive.sv
// Decodes the phase into device strobes and bus values, and captures read data.
module dram_seq_drive
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase_i,
  input  op_t               op_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  input  logic              row_open_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              rw_o,
  output logic              oe_n_o,
  output logic [BUS_W-1:0]  addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic             is_ref;
  logic [BUS_W-1:0] row_bus, col_bus, ref_bus;
  logic             rv_nx;

  assign is_ref  = (op_i == OP_REF);
  assign row_bus = BUS_W'(row_i);
  assign col_bus = BUS_W'(col_i);
  assign ref_bus = BUS_W'(ref_row_i);
  assign wdata_o = wdata_i;

  always_comb begin
    cs_n_o  = 1'b1;
    ras_n_o = !row_open_i;
    cas_n_o = 1'b1;
    rw_o    = 1'b1;
    oe_n_o  = 1'b1;
    addr_o  = '0;
    case (phase_i)
      ST_T1: begin
        cs_n_o  = 1'b0;
        ras_n_o = 1'b1;
        addr_o  = is_ref ? ref_bus : row_bus;
      end
      ST_T2: begin
        cs_n_o  = 1'b0;
        ras_n_o = 1'b0;
        addr_o  = is_ref ? ref_bus : row_bus;
      end
      ST_T3, ST_T4: begin
        cs_n_o  = 1'b0;
        ras_n_o = is_ref && (phase_i == ST_T4);
        if (is_ref) begin
          addr_o = ref_bus;
        end else begin
          addr_o  = col_bus;
          cas_n_o = 1'b0;
          rw_o    = (op_i != OP_WR);
          oe_n_o  = (op_i != OP_RD);
        end
      end
      default: ;
    endcase
  end

  assign rv_nx = (phase_i == ST_T4) && (op_i == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rvalid_o <= 1'b0;
    else
      rvalid_o <= rv_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_o <= '0;
    else if (rv_nx)
      rdata_o <= dram_rdata_i;
  end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 8,
  parameter int REF_INTERVAL = 64
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   host_req,
  input  logic                                   host_we,
  input  logic [ROW_W+COL_W-1:0]                 host_addr,
  input  logic [DATA_W-1:0]                      host_wdata,
  output logic                                   host_ready,
  output logic [DATA_W-1:0]                      host_rdata,
  output logic                                   host_rvalid,
  output logic                                   dram_cs_n,
  output logic                                   dram_ras_n,
  output logic                                   dram_cas_n,
  output logic                                   dram_rw,
  output logic                                   dram_oe_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]                      dram_wdata,
  input  logic [DATA_W-1:0]                      dram_rdata
);
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [1:0]        rst_sync;
  logic              rst_q;
  phase_t            phase;
  op_t               op;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              row_open, accept, grant, ref_done, hit;
  logic              ref_pend;
  logic [ROW_W-1:0]  ref_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  dram_seq_refresh #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_q),
    .grant_i (grant),
    .done_i  (ref_done),
    .pend_o  (ref_pend),
    .row_o   (ref_row)
  );

  dram_seq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_q),
    .req_i      (host_req),
    .we_i       (host_we),
    .addr_i     (host_addr),
    .wdata_i    (host_wdata),
    .ref_pend_i (ref_pend),
    .phase_o    (phase),
    .op_o       (op),
    .row_o      (row_q),
    .col_o      (col_q),
    .wdata_o    (wdata_q),
    .row_open_o (row_open),
    .ready_o    (host_ready),
    .accept_o   (accept),
    .grant_o    (grant),
    .ref_done_o (ref_done),
    .hit_o      (hit)
  );

  dram_seq_drive #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_drive (
    .clk          (clk),
    .rst_n        (rst_q),
    .phase_i      (phase),
    .op_i         (op),
    .row_i        (row_q),
    .col_i        (col_q),
    .ref_row_i    (ref_row),
    .row_open_i   (row_open),
    .wdata_i      (wdata_q),
    .dram_rdata_i (dram_rdata),
    .cs_n_o       (dram_cs_n),
    .ras_n_o      (dram_ras_n),
    .cas_n_o      (dram_cas_n),
    .rw_o         (dram_rw),
    .oe_n_o       (dram_oe_n),
    .addr_o       (dram_addr),
    .wdata_o      (dram_wdata),
    .rdata_o      (host_rdata),
    .rvalid_o     (host_rvalid)
  );

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_q,
  input phase_t           phase,
  input op_t              op,
  input logic             ready,
  input logic             accept,
  input logic             hit,
  input logic             ref_pend,
  input logic [ROW_W-1:0] ref_row,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             rw,
  input logic             oe_n,
  input logic             rvalid
);

  p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !cas_n |-> !ras_n);

  p_write_level_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !rw |-> (!cas_n && op == OP_WR));

  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !oe_n |-> (!cas_n && rw));

  p_rvalid_after_t4_r4: assert property (@(posedge clk) disable iff (!rst_q)
    rvalid |-> ($past(phase) == ST_T4 && $past(op) == OP_RD));

  p_hit_goes_t3_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && hit) |=> (phase == ST_T3));

  p_ref_no_cas_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_REF && phase != ST_IDLE) |-> cas_n);

  p_ref_row_step_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_REF && phase == ST_T4) |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

  p_ref_priority_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (phase == ST_IDLE && ref_pend) |=> (phase == ST_T1 && op == OP_REF));

  p_ready_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_q)
    ready |-> cs_n);

endmodule

bind dram_seq dram_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .phase    (phase),
  .op       (op),
  .ready    (host_ready),
  .accept   (accept),
  .hit      (hit),
  .ref_pend (ref_pend),
  .ref_row  (ref_row),
  .cs_n     (dram_cs_n),
  .ras_n    (dram_ras_n),
  .cas_n    (dram_cas_n),
  .rw       (dram_rw),
  .oe_n     (dram_oe_n),
  .rvalid   (host_rvalid)
);

// File: tb/tb_dram_seq.sv
module tb_dram_seq;
  localparam int CLK_PERIOD = 20;
  localparam int RW = 4;
  localparam int CW = 4;
  localparam int DW = 8;
  localparam int IV = 37;
  localparam int AW = RW + CW;
  localparam int BW = 4;

  logic          clk, rst_n;
  logic          host_req, host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          host_ready, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic          dram_cs_n, dram_ras_n, dram_cas_n, dram_rw, dram_oe_n;
  logic [BW-1:0] dram_addr;
  logic [DW-1:0] dram_wdata, dram_rdata;

  dram_seq #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .REF_INTERVAL(IV)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .dram_cs_n(dram_cs_n),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_rw(dram_rw),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int reads_issued = 0;
  int reads_seen = 0;
  int collisions = 0;
  int refreshes = 0;
  int hits = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h time=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // ---------------- DRAM array model (samples mid-cycle) ----------------
  logic [DW-1:0] mem [256];
  logic [RW-1:0] mrow = '0;
  bit            prev_ras_n = 1'b1;

  always @(negedge clk) begin
    if (!dram_cs_n) begin
      if (prev_ras_n && !dram_ras_n) mrow = dram_addr[RW-1:0];
      if (!dram_cas_n && !dram_rw) mem[{mrow, dram_addr[CW-1:0]}] = dram_wdata;
    end
    prev_ras_n = dram_ras_n;
  end

  assign dram_rdata = (!dram_oe_n && !dram_cas_n) ? mem[{mrow, dram_addr[CW-1:0]}] : '0;

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] exp_mem [256];
  int      m_ph, m_op, m_tmr;      // m_op: 0 read, 1 write, 2 refresh
  bit      m_open, m_pend, m_rv, m_after_ref;
  int      m_row, m_col, m_wd, m_rr, m_raddr, m_rd;
  string   m_tag = "R2";
  bit      rs1, rs2;

  task automatic m_reset();
    m_ph = 0; m_op = 0; m_tmr = 0; m_open = 0; m_pend = 0; m_rv = 0;
    m_row = 0; m_col = 0; m_wd = 0; m_rr = 0; m_after_ref = 0; m_tag = "R2";
  endtask

  task automatic m_step();
    bit wrap, hit;
    wrap = (m_tmr == IV - 1);
    m_tmr = wrap ? 0 : m_tmr + 1;
    m_rv = 0;
    if (m_ph == 0) begin
      if (m_pend && host_req) collisions++;
      if (m_pend) begin
        m_pend = 0; m_op = 2; m_open = 0; m_ph = 1; m_tag = "R7"; refreshes++;
      end else if (host_req) begin
        m_row = int'(host_addr[AW-1:CW]);
        m_col = int'(host_addr[CW-1:0]);
        hit = m_open && (m_orow_q() == m_row);
        m_op = host_we ? 1 : 0;
        m_wd = int'(host_wdata);
        m_raddr = int'(host_addr);
        if (host_we) exp_mem[host_addr] = host_wdata;
        m_tag = hit ? "R5" : (m_after_ref ? "R9" : "R2");
        if (hit) hits++;
        m_after_ref = 0;
        m_open = 1;
        m_orow = m_row;
        m_ph = hit ? 3 : 1;
      end
    end else if (m_ph == 4) begin
      if (m_op == 2) begin
        m_rr = (m_rr == (1 << RW) - 1) ? 0 : m_rr + 1;
        m_after_ref = 1;
      end
      if (m_op == 0) begin
        m_rv = 1;
        m_rd = int'(exp_mem[m_raddr]);
      end
      m_ph = 0;
    end else begin
      if (m_ph != 0 && m_op != 2 && wrap) collisions++;
      m_ph = m_ph + 1;
    end
    if (wrap) m_pend = 1;
  endtask

  int m_orow = 0;
  function automatic int m_orow_q();
    return m_orow;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; m_reset();
    end else begin
      if (!rs2) m_reset(); else m_step();
      rs2 = rs1; rs1 = 1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    int e_cs, e_ras, e_cas, e_rw, e_oe, e_addr, e_rdy;
    bool_dummy();
    e_cs = 1; e_ras = m_open ? 0 : 1; e_cas = 1; e_rw = 1; e_oe = 1; e_addr = 0;
    if (m_ph == 1 || m_ph == 2) begin
      e_cs = 0; e_ras = (m_ph == 1) ? 1 : 0;
      e_addr = (m_op == 2) ? m_rr : m_row;
    end else if (m_ph == 3 || m_ph == 4) begin
      e_cs = 0;
      if (m_op == 2) begin
        e_ras = (m_ph == 4) ? 1 : 0; e_addr = m_rr;
      end else begin
        e_ras = 0; e_cas = 0; e_addr = m_col;
        e_rw = (m_op == 1) ? 0 : 1;
        e_oe = (m_op == 0) ? 0 : 1;
      end
    end
    e_rdy = (m_ph == 0 && !m_pend) ? 1 : 0;
    chk(m_pend ? "R8" : "R6", "host_ready", 32'(host_ready), 32'(e_rdy));
    chk("R10", "dram_cs_n", 32'(dram_cs_n), 32'(e_cs));
    chk(m_tag, "dram_ras_n", 32'(dram_ras_n), 32'(e_ras));
    chk(m_tag, "dram_cas_n", 32'(dram_cas_n), 32'(e_cas));
    chk(m_tag, "dram_addr", 32'(dram_addr), 32'(e_addr));
    chk("R3", "dram_rw", 32'(dram_rw), 32'(e_rw));
    chk("R4", "dram_oe_n", 32'(dram_oe_n), 32'(e_oe));
    if (e_rw == 0) chk("R3", "dram_wdata", 32'(dram_wdata), 32'(m_wd));
    chk("R4", "host_rvalid", 32'(host_rvalid), 32'(m_rv));
    if (m_rv) chk("R4", "host_rdata", 32'(host_rdata), 32'(m_rd));
    if (host_rvalid) reads_seen++;
  end

  function automatic void bool_dummy();
  endfunction

  // ---------------- stimulus ----------------
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    if (!wr) reads_issued++;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      exp_mem[i] = '0;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1: reset state
    chk("R1", "host_ready", 32'(host_ready), 32'd1);
    chk("R1", "dram_cs_n", 32'(dram_cs_n), 32'd1);
    chk("R1", "dram_ras_n", 32'(dram_ras_n), 32'd1);
    chk("R1", "dram_cas_n", 32'(dram_cas_n), 32'd1);
    chk("R1", "dram_rw", 32'(dram_rw), 32'd1);
    chk("R1", "dram_oe_n", 32'(dram_oe_n), 32'd1);
    chk("R1", "host_rvalid", 32'(host_rvalid), 32'd0);

    // Directed: miss write, page-hit read/write, miss, return to row
    access(1'b1, 8'h12, 8'hA5);
    access(1'b0, 8'h12, 8'h00);
    access(1'b1, 8'h13, 8'h3C);
    access(1'b0, 8'h47, 8'h00);
    access(1'b0, 8'h13, 8'h00);
    // Let a refresh close the row, then reuse the same row (R9)
    idle(IV + 5);
    access(1'b0, 8'h13, 8'h00);
    access(1'b0, 8'h12, 8'h00);

    // Dense mixed traffic, rows limited to four for frequent hits
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(lf[0], {2'b00, lf[5:0]}, lf[15:8]);
      if (lf[7:6] == 2'b11) idle(2);
      else if (lf[7:6] == 2'b10) idle(1);
    end
    idle(IV * 2);

    // R11: one valid pulse per accepted read
    chk("R11", "reads_seen", 32'(reads_seen), 32'(reads_issued));
    // R8: the stream produced refresh/host collisions
    chk("R8", "collisions_seen", 32'(collisions > 0), 32'd1);
    // R7: enough refreshes to wrap the refresh-row counter
    chk("R7", "refresh_wrap_seen", 32'(refreshes > (1 << RW)), 32'd1);
    // R5: page hits occurred
    chk("R5", "hits_seen", 32'(hits > 0), 32'd1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired time=%0t", $time);
      summary();
      $finish;
    end
  end

endmodule